// File: doc/BRIEF.md
# Debug Memory Breakpoint Unit

This block watches the memory traffic of a processor that has one program space and two data spaces (X and Y), and raises a breakpoint when an access of a chosen kind lands inside a chosen address window. Program-space watching picks one access class. The classes are the first word of instructions that actually execute, explicit program-memory moves, any core access to program space, or DMA accesses. Data-space watching qualifies the access by direction (read, write or both), by space (X or Y) and by master (core or DMA).

Software sets the block up through a small register port. A control register holds the enable and select fields and two sticky "occurred" flags. Four bound registers hold the program and data windows, and a countdown register holds the number of qualifying matches to let pass before firing. Each qualifying match decrements the count. A match that arrives with the count at zero produces a one-cycle breakpoint pulse and sets the matching flag.

Top module: `bkpt_unit`

## Requirements
- R1: After reset the control register, all four bound registers and the countdown read as zero, and `bkpt_pulse` is low.
- R2: Register select codes are 0 control, 1 program low bound, 2 program high bound, 3 data low bound, 4 data high bound, 5 countdown. `cfg_rdata` returns the selected register in the same cycle. Control bits [1:0] program enable, [3:2] program select, [5:4] data enable, [7:6] data select and [8] trace enable read back as written. Bits [15:9], [18] and [31:19] always read zero.
- R3: A window match needs low <= address <= high, compared unsigned and inclusive at both ends. When low > high the window never matches.
- R4: With program select 0, only `ex_valid` (the first word of an executed instruction, at `ex_addr`) can match. Fetches reported on the `pf_*` port, such as killed words or second words, are ignored.
- R5: With program select 1, only `pf_valid` accesses with `pf_src` = 1 (explicit program move) can match.
- R6: With program select 2, every core program access (`pf_src` = 0 fetch or 1 move, including false fetches and second words) can match, and DMA (`pf_src` = 2) cannot.
- R7: With program select 3, only `pf_valid` accesses with `pf_src` = 2 (DMA) can match.
- R8: Program enable 0 disables program breakpoints. Any nonzero value enables them.
- R9: Data enable 0 disables data breakpoints. A value of 1 matches writes only, 2 matches reads only, and 3 matches both.
- R10: Data select bit 1 picks the master (1 = DMA) and bit 0 picks the space (1 = Y). A data access matches only when `{da_dma, da_space_y}` equals the select field.
- R11: A cycle with a program or data match decrements a nonzero countdown and does not fire. With the countdown at zero the match fires, and `bkpt_pulse` goes high for exactly the next cycle while the countdown stays at zero. A countdown write overrides the decrement in its own cycle.
- R12: A firing program match sets control bit 16, and a firing data match sets bit 17. A flag stays set until a control write carries 0 in that bit. Writing 1 leaves the flag unchanged, and a firing match outranks a clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents |
| pf_valid | input | 1 | Program-space access this cycle |
| pf_src | input | 2 | Access class: 0 fetch, 1 move, 2 DMA |
| pf_addr | input | AW | Program access address |
| ex_valid | input | 1 | First word of an executed instruction |
| ex_addr | input | AW | Address of that executed instruction |
| da_valid | input | 1 | Data-space access this cycle |
| da_write | input | 1 | 1 = write, 0 = read |
| da_space_y | input | 1 | 1 = Y space, 0 = X space |
| da_dma | input | 1 | 1 = DMA master, 0 = core |
| da_addr | input | AW | Data access address |
| bkpt_pulse | output | 1 | One-cycle breakpoint indication |

## Verification
Random traffic across all program classes, data directions, spaces and masters runs over small address windows, with bounds, control fields and countdown values reloaded at random. This separates a wrong class or qualifier decode from a wrong window compare. Directed sequences place accesses exactly on each bound, one step outside each bound, and inside an inverted window, which catches strict-versus-inclusive and signed-compare mistakes. A countdown of two followed by repeated matches distinguishes firing on the wrong count from failing to stay at zero. Flag writes with 1 and 0 show whether software can set a flag or only clear it.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    SRC_FETCH = 2'd0,
    SRC_MOVE  = 2'd1,
    SRC_DMA   = 2'd2,
    SRC_NONE  = 2'd3
  } psrc_e;

  typedef enum logic [1:0] {
    PS_EXEC = 2'd0,
    PS_MOVE = 2'd1,
    PS_ANY  = 2'd2,
    PS_DMA  = 2'd3
  } psel_e;

  localparam logic [2:0] RS_CTRL = 3'd0;
  localparam logic [2:0] RS_PLO  = 3'd1;
  localparam logic [2:0] RS_PHI  = 3'd2;
  localparam logic [2:0] RS_DLO  = 3'd3;
  localparam logic [2:0] RS_DHI  = 3'd4;
  localparam logic [2:0] RS_CNT  = 3'd5;

  localparam int PFLAG_BIT = 16;
  localparam int DFLAG_BIT = 17;

  // Inclusive unsigned window test on zero-extended operands.
  function automatic logic in_window(input logic [63:0] a,
                                     input logic [63:0] lo,
                                     input logic [63:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Does a program-port access of class src belong to selection sel?
  function automatic logic pclass_ok(input psel_e sel, input psrc_e src);
    case (sel)
      PS_MOVE: return src == SRC_MOVE;
      PS_ANY:  return (src == SRC_FETCH) || (src == SRC_MOVE);
      PS_DMA:  return src == SRC_DMA;
      default: return 1'b0;
    endcase
  endfunction

  // Direction qualifier: bit0 of enable allows writes, bit1 allows reads.
  function automatic logic ddir_ok(input logic [1:0] en, input logic wr);
    return wr ? en[0] : en[1];
  endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [31:0]   wdata,
  input  logic          set_pflag,
  input  logic          set_dflag,
  input  logic [CW-1:0] cnt_val,
  output logic [1:0]    pen,
  output logic [1:0]    psel,
  output logic [1:0]    den,
  output logic [1:0]    dsel,
  output logic [AW-1:0] plo,
  output logic [AW-1:0] phi,
  output logic [AW-1:0] dlo,
  output logic [AW-1:0] dhi,
  output logic          cnt_load,
  output logic [31:0]   rdata
);

  logic       tme;
  logic       pflag, dflag;
  logic       ctrl_we;
  logic       wdata_unused;
  logic [31:0] ctrl_rd;

  assign wdata_unused = ^wdata;
  assign ctrl_we  = we && (sel == RS_CTRL);
  assign cnt_load = we && (sel == RS_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen  <= '0;
      psel <= '0;
      den  <= '0;
      dsel <= '0;
      tme  <= 1'b0;
    end else if (ctrl_we) begin
      pen  <= wdata[1:0];
      psel <= wdata[3:2];
      den  <= wdata[5:4];
      dsel <= wdata[7:6];
      tme  <= wdata[8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plo <= '0;
      phi <= '0;
      dlo <= '0;
      dhi <= '0;
    end else if (we) begin
      case (sel)
        RS_PLO:  plo <= wdata[AW-1:0];
        RS_PHI:  phi <= wdata[AW-1:0];
        RS_DLO:  dlo <= wdata[AW-1:0];
        RS_DHI:  dhi <= wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pflag <= 1'b0;
      dflag <= 1'b0;
    end else begin
      if (set_pflag)                         pflag <= 1'b1;
      else if (ctrl_we && !wdata[PFLAG_BIT]) pflag <= 1'b0;
      if (set_dflag)                         dflag <= 1'b1;
      else if (ctrl_we && !wdata[DFLAG_BIT]) dflag <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[1:0]       = pen;
    ctrl_rd[3:2]       = psel;
    ctrl_rd[5:4]       = den;
    ctrl_rd[7:6]       = dsel;
    ctrl_rd[8]         = tme;
    ctrl_rd[PFLAG_BIT] = pflag;
    ctrl_rd[DFLAG_BIT] = dflag;
  end

  always_comb begin
    case (sel)
      RS_CTRL: rdata = ctrl_rd;
      RS_PLO:  rdata = 32'(plo);
      RS_PHI:  rdata = 32'(phi);
      RS_DLO:  rdata = 32'(dlo);
      RS_DHI:  rdata = 32'(dhi);
      RS_CNT:  rdata = 32'(cnt_val);
      default: rdata = '0;
    endcase
  end

  assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl_rd[8:0] == $past(wdata[8:0]));

  assert_pflag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pflag && !(ctrl_we && !wdata[PFLAG_BIT]) |=> pflag);

  assert_dflag_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set_dflag |=> dflag);

endmodule

// File: rtl/bkpt_prog_match.sv
module bkpt_prog_match
  import bkpt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pen,
  input  logic [1:0]    psel,
  input  logic [AW-1:0] plo,
  input  logic [AW-1:0] phi,
  input  logic          pf_valid,
  input  logic [1:0]    pf_src,
  input  logic [AW-1:0] pf_addr,
  input  logic          ex_valid,
  input  logic [AW-1:0] ex_addr,
  output logic          prog_hit
);

  logic          armed;
  logic          cand_valid;
  logic [AW-1:0] cand_addr;
  logic          in_win;

  assign armed = |pen;

  // Selection 0 watches retired first words; the others watch the access port.
  always_comb begin
    if (psel_e'(psel) == PS_EXEC) begin
      cand_valid = ex_valid;
      cand_addr  = ex_addr;
    end else begin
      cand_valid = pf_valid && pclass_ok(psel_e'(psel), psrc_e'(pf_src));
      cand_addr  = pf_addr;
    end
  end

  assign in_win   = in_window(64'(cand_addr), 64'(plo), 64'(phi));
  assign prog_hit = armed && cand_valid && in_win;

  assert_exec_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_hit && psel == 2'd0 |-> ex_valid);

  assert_dma_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_hit && psel == 2'd3 |-> pf_valid && pf_src == 2'd2);

  assert_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_hit |-> pen != 2'd0);

endmodule

// File: rtl/bkpt_data_match.sv
module bkpt_data_match
  import bkpt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    den,
  input  logic [1:0]    dsel,
  input  logic [AW-1:0] dlo,
  input  logic [AW-1:0] dhi,
  input  logic          da_valid,
  input  logic          da_write,
  input  logic          da_space_y,
  input  logic          da_dma,
  input  logic [AW-1:0] da_addr,
  output logic          data_hit
);

  logic dir_ok, path_ok, in_win;

  assign dir_ok   = ddir_ok(den, da_write);
  assign path_ok  = (dsel[1] == da_dma) && (dsel[0] == da_space_y);
  assign in_win   = in_window(64'(da_addr), 64'(dlo), 64'(dhi));
  assign data_hit = da_valid && dir_ok && path_ok && in_win;

  assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_hit |-> (da_addr >= dlo) && (da_addr <= dhi));

  assert_write_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_hit && den == 2'b01 |-> da_write);

  assert_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_hit |-> dsel == {da_dma, da_space_y});

endmodule

// File: rtl/bkpt_counter.sv
module bkpt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          fire
);

  logic at_zero;

  assign at_zero = (cnt == '0);
  assign fire    = hit && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (hit && !at_zero)  cnt <= cnt - CW'(1);
  end

  assert_decrement_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !at_zero && !load |=> cnt == $past(cnt) - CW'(1));

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          pf_valid,
  input  logic [1:0]    pf_src,
  input  logic [AW-1:0] pf_addr,
  input  logic          ex_valid,
  input  logic [AW-1:0] ex_addr,
  input  logic          da_valid,
  input  logic          da_write,
  input  logic          da_space_y,
  input  logic          da_dma,
  input  logic [AW-1:0] da_addr,
  output logic          bkpt_pulse
);

  logic [1:0]    pen, psel, den, dsel;
  logic [AW-1:0] plo, phi, dlo, dhi;
  logic          cnt_load;
  logic [CW-1:0] cnt;
  logic          prog_hit, data_hit, any_hit, fire;

  bkpt_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .set_pflag(fire && prog_hit), .set_dflag(fire && data_hit), .cnt_val(cnt),
    .pen(pen), .psel(psel), .den(den), .dsel(dsel),
    .plo(plo), .phi(phi), .dlo(dlo), .dhi(dhi),
    .cnt_load(cnt_load), .rdata(cfg_rdata)
  );

  bkpt_prog_match #(.AW(AW)) u_prog (
    .clk(clk), .rst_n(rst_n), .pen(pen), .psel(psel), .plo(plo), .phi(phi),
    .pf_valid(pf_valid), .pf_src(pf_src), .pf_addr(pf_addr),
    .ex_valid(ex_valid), .ex_addr(ex_addr), .prog_hit(prog_hit)
  );

  bkpt_data_match #(.AW(AW)) u_data (
    .clk(clk), .rst_n(rst_n), .den(den), .dsel(dsel), .dlo(dlo), .dhi(dhi),
    .da_valid(da_valid), .da_write(da_write), .da_space_y(da_space_y),
    .da_dma(da_dma), .da_addr(da_addr), .data_hit(data_hit)
  );

  assign any_hit = prog_hit || data_hit;

  bkpt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hit(any_hit), .load(cnt_load),
    .load_val(cfg_wdata[CW-1:0]), .cnt(cnt), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bkpt_pulse <= 1'b0;
    else        bkpt_pulse <= fire;
  end

  assert_pulse_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_pulse |-> $past(cnt) == '0 && $past(any_hit));

  assert_no_pulse_counting_R11: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit && cnt != '0 |=> !bkpt_pulse);

endmodule

// File: tb/test_bkpt_unit.sv
module test_bkpt_unit;

  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = 3'd0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          pf_valid = 1'b0;
  logic [1:0]    pf_src = 2'd0;
  logic [AW-1:0] pf_addr = '0;
  logic          ex_valid = 1'b0;
  logic [AW-1:0] ex_addr = '0;
  logic          da_valid = 1'b0, da_write = 1'b0, da_space_y = 1'b0, da_dma = 1'b0;
  logic [AW-1:0] da_addr = '0;
  logic          bkpt_pulse;

  always #5 clk = ~clk;

  bkpt_unit #(.AW(AW), .CW(CW)) i_bkpt_unit (.*);

  int n_vec = 0;
  int n_bad = 0;

  // Reference state (value the design holds after the most recent edge)
  logic [8:0]    m_cfg;
  logic          m_pf, m_df, m_pulse;
  logic [AW-1:0] m_plo, m_phi, m_dlo, m_dhi;
  logic [CW-1:0] m_cnt;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic m_win(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                 input logic [AW-1:0] hi);
    return !(a < lo) && !(a > hi);
  endfunction

  function automatic logic m_prog();
    logic v;
    logic [AW-1:0] a;
    if (m_cfg[1:0] == 2'd0) return 1'b0;
    a = pf_addr;
    case (m_cfg[3:2])
      2'd0: begin v = ex_valid; a = ex_addr; end
      2'd1: v = pf_valid && pf_src == 2'd1;
      2'd2: v = pf_valid && pf_src < 2'd2;
      default: v = pf_valid && pf_src == 2'd2;
    endcase
    return v && m_win(a, m_plo, m_phi);
  endfunction

  function automatic logic m_data();
    logic dir;
    case (m_cfg[5:4])
      2'd0: dir = 1'b0;
      2'd1: dir = da_write;
      2'd2: dir = !da_write;
      default: dir = 1'b1;
    endcase
    return da_valid && dir && (m_cfg[7] == da_dma) && (m_cfg[6] == da_space_y)
           && m_win(da_addr, m_dlo, m_dhi);
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] s);
    case (s)
      3'd0: return {14'd0, m_df, m_pf, 7'd0, m_cfg};
      3'd1: return 32'(m_plo);
      3'd2: return 32'(m_phi);
      3'd3: return 32'(m_dlo);
      3'd4: return 32'(m_dhi);
      3'd5: return 32'(m_cnt);
      default: return 32'd0;
    endcase
  endfunction

  // One clock: predict, wait for the edge, compare.
  task automatic tick();
    logic ph, dh, fire;
    ph = m_prog();
    dh = m_data();
    fire = (ph || dh) && (m_cnt == '0);
    m_pulse = fire;
    if (fire && ph) m_pf = 1'b1;
    else if (cfg_we && cfg_sel == 3'd0 && !cfg_wdata[16]) m_pf = 1'b0;
    if (fire && dh) m_df = 1'b1;
    else if (cfg_we && cfg_sel == 3'd0 && !cfg_wdata[17]) m_df = 1'b0;
    if (cfg_we && cfg_sel == 3'd5) m_cnt = cfg_wdata[CW-1:0];
    else if ((ph || dh) && m_cnt != '0) m_cnt = m_cnt - 1'b1;
    if (cfg_we) begin
      case (cfg_sel)
        3'd0: m_cfg = cfg_wdata[8:0];
        3'd1: m_plo = cfg_wdata[AW-1:0];
        3'd2: m_phi = cfg_wdata[AW-1:0];
        3'd3: m_dlo = cfg_wdata[AW-1:0];
        3'd4: m_dhi = cfg_wdata[AW-1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    check("R11 pulse", 32'(bkpt_pulse), 32'(m_pulse));
    check(cfg_sel == 3'd0 ? "R12 ctrl" : (cfg_sel == 3'd5 ? "R11 count" : "R2 bound"),
          cfg_rdata, m_read(cfg_sel));
  endtask

  task automatic idle();
    cfg_we = 1'b0; pf_valid = 1'b0; ex_valid = 1'b0; da_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] v);
    idle();
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pacc(input logic [1:0] src, input logic [AW-1:0] a);
    idle(); pf_valid = 1'b1; pf_src = src; pf_addr = a; tick(); idle();
  endtask

  task automatic xacc(input logic [AW-1:0] a);
    idle(); ex_valid = 1'b1; ex_addr = a; tick(); idle();
  endtask

  task automatic dacc(input logic w, input logic y, input logic d, input logic [AW-1:0] a);
    idle(); da_valid = 1'b1; da_write = w; da_space_y = y; da_dma = d; da_addr = a;
    tick(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_cfg = '0; m_pf = 0; m_df = 0; m_pulse = 0;
    m_plo = '0; m_phi = '0; m_dlo = '0; m_dhi = '0; m_cnt = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl", cfg_rdata, 32'd0);
    check("R1 pulse", 32'(bkpt_pulse), 32'd0);
    cfg_sel = 3'd5; #1;
    check("R1 count", cfg_rdata, 32'd0);

    // R2 writable fields and reserved zeros, flags not settable
    wr(3'd0, 32'hFFFF_FFFF);
    cfg_sel = 3'd0; #1;
    check("R2 ctrl readback", cfg_rdata, 32'h0000_01FF);

    // R4 executed-first-word selection
    wr(3'd1, 32'd10); wr(3'd2, 32'd20); wr(3'd5, 32'd0); wr(3'd0, 32'h1);
    pacc(2'd0, 16'd15);
    check("R4 fetch ignored", 32'(bkpt_pulse), 32'd0);
    xacc(16'd15);
    check("R4 executed word", 32'(bkpt_pulse), 32'd1);
    cfg_sel = 3'd0; #1;
    check("R12 pflag set", 32'(cfg_rdata[16]), 32'd1);
    // R3 bounds
    xacc(16'd10); check("R3 low bound", 32'(bkpt_pulse), 32'd1);
    xacc(16'd20); check("R3 high bound", 32'(bkpt_pulse), 32'd1);
    xacc(16'd21); check("R3 above high", 32'(bkpt_pulse), 32'd0);
    xacc(16'd9);  check("R3 below low", 32'(bkpt_pulse), 32'd0);

    // R5 explicit move only
    wr(3'd0, 32'h0001_0005);
    pacc(2'd1, 16'd12); check("R5 move", 32'(bkpt_pulse), 32'd1);
    pacc(2'd0, 16'd12); check("R5 fetch", 32'(bkpt_pulse), 32'd0);
    pacc(2'd2, 16'd12); check("R5 dma", 32'(bkpt_pulse), 32'd0);
    // R6 any core access
    wr(3'd0, 32'h0001_0009);
    pacc(2'd0, 16'd12); check("R6 fetch", 32'(bkpt_pulse), 32'd1);
    pacc(2'd1, 16'd12); check("R6 move", 32'(bkpt_pulse), 32'd1);
    pacc(2'd2, 16'd12); check("R6 dma", 32'(bkpt_pulse), 32'd0);
    // R7 DMA only
    wr(3'd0, 32'h0001_000D);
    pacc(2'd2, 16'd12); check("R7 dma", 32'(bkpt_pulse), 32'd1);
    pacc(2'd0, 16'd12); check("R7 fetch", 32'(bkpt_pulse), 32'd0);
    // R8 program enable off
    wr(3'd0, 32'h0001_000C);
    pacc(2'd2, 16'd12); check("R8 disabled", 32'(bkpt_pulse), 32'd0);

    // R9 data direction
    wr(3'd3, 32'd30); wr(3'd4, 32'd40); wr(3'd0, 32'h0001_0010);
    dacc(1, 0, 0, 16'd35); check("R9 write on wr-only", 32'(bkpt_pulse), 32'd1);
    dacc(0, 0, 0, 16'd35); check("R9 read on wr-only", 32'(bkpt_pulse), 32'd0);
    wr(3'd0, 32'h0003_0020);
    dacc(0, 0, 0, 16'd30); check("R9 read on rd-only", 32'(bkpt_pulse), 32'd1);
    dacc(1, 0, 0, 16'd30); check("R9 write on rd-only", 32'(bkpt_pulse), 32'd0);
    wr(3'd0, 32'h0003_0000);
    dacc(1, 0, 0, 16'd40); check("R9 disabled", 32'(bkpt_pulse), 32'd0);
    // R10 space and master
    wr(3'd0, 32'h0003_0070);
    dacc(0, 1, 0, 16'd33); check("R10 Y core", 32'(bkpt_pulse), 32'd1);
    dacc(0, 0, 0, 16'd33); check("R10 X core", 32'(bkpt_pulse), 32'd0);
    dacc(1, 1, 1, 16'd33); check("R10 Y dma", 32'(bkpt_pulse), 32'd0);
    wr(3'd0, 32'h0003_00F0);
    dacc(1, 1, 1, 16'd33); check("R10 Y dma sel", 32'(bkpt_pulse), 32'd1);

    // R12 flag clear, and R11 countdown
    wr(3'd0, 32'h0001_0070);
    cfg_sel = 3'd0; #1;
    check("R12 dflag cleared", 32'(cfg_rdata[17]), 32'd0);
    check("R12 pflag kept", 32'(cfg_rdata[16]), 32'd1);
    wr(3'd5, 32'd2);
    dacc(0, 1, 0, 16'd31); check("R11 count 2", 32'(bkpt_pulse), 32'd0);
    dacc(0, 1, 0, 16'd31); check("R11 count 1", 32'(bkpt_pulse), 32'd0);
    dacc(0, 1, 0, 16'd31); check("R11 fire", 32'(bkpt_pulse), 32'd1);
    idle(); tick(); check("R11 one cycle", 32'(bkpt_pulse), 32'd0);
    dacc(0, 1, 0, 16'd31); check("R11 stays zero", 32'(bkpt_pulse), 32'd1);

    // R3 inverted window
    wr(3'd3, 32'd50);
    dacc(0, 1, 0, 16'd45); check("R3 inverted", 32'(bkpt_pulse), 32'd0);

    // Random traffic against the reference model
    for (int i = 0; i < 4000; i++) begin
      idle();
      if ($urandom_range(0, 7) == 0) begin
        cfg_we = 1'b1;
        cfg_sel = 3'($urandom_range(0, 5));
        case (cfg_sel)
          3'd5:    cfg_wdata = 32'($urandom_range(0, 3));
          3'd0:    cfg_wdata = $urandom();
          default: cfg_wdata = 32'($urandom_range(0, 63));
        endcase
      end else begin
        cfg_sel = 3'($urandom_range(0, 5));
      end
      pf_valid = 1'($urandom()); pf_src = 2'($urandom());
      pf_addr = 16'($urandom_range(0, 63));
      ex_valid = 1'($urandom()); ex_addr = 16'($urandom_range(0, 63));
      da_valid = 1'($urandom()); da_write = 1'($urandom());
      da_space_y = 1'($urandom()); da_dma = 1'($urandom());
      da_addr = 16'($urandom_range(0, 63));
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule